// File: doc/BRIEF.md
# Serial PHY Management Master

This block is the management-bus master of an Ethernet MAC subsystem. It derives a management clock (MDC) from the system clock, drives the bidirectional data line through separate output, output-enable and input pins, and performs one register access per request. A host starts an access with a single-cycle pulse. With the request it gives the direction, the addressing style, a 5-bit PHY address, an address and, for writes, 16 data bits. It then waits for a one-cycle completion pulse that carries the read data and an error flag.

Two addressing styles are supported. A direct access sends one frame that carries a 5-bit register number. An extended access takes a 21-bit address: bits 20:16 select the device and bits 15:0 the register. The block sends an address-setting frame for the extended access on its own, and then sends the data frame to the same PHY and device. On reads the block checks the turnaround bit from the PHY. If the PHY does not pull that bit low, the block clocks the bus clear and reports an error instead of returning stale data.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 bits of 1 sent with the output enable high.
- R2: A direct frame carries start code 01, opcode 10 for read or 01 for write, then the 5-bit PHY address and the 5-bit register number (address bits 4:0), each sent most significant bit first.
- R3: An extended access sends two frames with start code 00. The first frame has opcode 00, the device field (address bits 20:16) and, as data, address bits 15:0. The second frame has the same PHY and device fields and opcode 11 for read or 01 for write.
- R4: On write frames and address frames the master drives the turnaround as 1 then 0, then sends the 16 data bits most significant bit first.
- R5: On a read frame the output enable drops after the register field. The master samples one turnaround bit and then captures 16 data bits, most significant bit first, into the read data. The error flag is 0 when the turnaround bit was 0.
- R6: If the sampled turnaround bit is 1, the master gives 32 more MDC cycles with the line released and completes with the error flag at 1 and read data 16'hFFFF. A read frame then takes 79 MDC cycles.
- R7: After the last data bit the line is released for one extra MDC cycle. A write or address frame is 65 MDC cycles long and a good read frame is 64.
- R8: MDC stays high for exactly HIGH_CYC system clocks and stays low for at least LOW_CYC. The data output and the output enable change only while MDC is low. Read data is sampled in the last system clock of the high phase.
- R9: Busy rises in the cycle after an accepted start and stays high until done. Done is a one-cycle pulse, and busy is low in that cycle. A start that arrives while busy is high is ignored.
- R10: After reset, and whenever the block is idle, MDC is low, the output enable is low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = extended (two-frame) access |
| req_phy | input | 5 | PHY address |
| req_addr | input | 21 | Register number in bits 4:0 (direct), or device and register address (extended) |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid with done |
| rsp_err | output | 1 | Turnaround error, valid with done |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with LOW_CYC = 2 and HIGH_CYC = 3. Two is the smallest low phase that still lets the data change and settle before the rising edge. With these values a full extended access, including the flush path, takes only a few hundred system clocks, so direct and extended reads and writes and both turnaround outcomes all fit in one short run. The short phases also put the high-phase sample point and the one-clock gap between a data update and the MDC rise under test at their tightest spacing.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_LEN   = 32;
  localparam int FLD_LEN   = 5;
  localparam int DATA_LEN  = 16;
  localparam int FLUSH_LEN = 32;
  // preamble + start + opcode + two 5-bit fields
  localparam int HDR_LEN   = PRE_LEN + 2 + 2 + 2 * FLD_LEN;
  // header + two turnaround bits + data
  localparam int SH_LEN    = HDR_LEN + 2 + DATA_LEN;
  localparam int IDX_W     = $clog2(HDR_LEN + FLUSH_LEN + 2);

  localparam logic [1:0] ST_DIRECT = 2'b01;
  localparam logic [1:0] ST_EXT    = 2'b00;
  localparam logic [1:0] OP_ADDR   = 2'b00;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_RD_DIR = 2'b10;
  localparam logic [1:0] OP_RD_EXT = 2'b11;

  typedef struct packed {
    logic [1:0]          st;
    logic [1:0]          op;
    logic [FLD_LEN-1:0]  phy;
    logic [FLD_LEN-1:0]  fld;
    logic [DATA_LEN-1:0] data;
    logic                rd;
  } frame_t;

  typedef enum logic [1:0] {
    C_IDLE,
    C_ADDR,
    C_ACC
  } ctl_t;

endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
  parameter int LOW_CYC  = 24,
  parameter int HIGH_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic bit_start,
  output logic bit_end
);

  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (!mdc_q) begin
      if (cnt_q == LOW_LAST) begin
        cnt_d = '0;
        mdc_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else begin
      if (cnt_q == HIGH_LAST) begin
        cnt_d = '0;
        mdc_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign bit_start = run && !mdc_q && (cnt_q == '0);
  assign bit_end   = run && mdc_q && (cnt_q == HIGH_LAST);

  // R8: a stopped phase generator leaves MDC low
  p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  frame_t              frm,
  input  logic                bit_start,
  input  logic                bit_end,
  input  logic                mdc,
  input  logic                mdio_i,
  output logic                run,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic                fdone,
  output logic [DATA_LEN-1:0] frd,
  output logic                ferr
);

  localparam logic [IDX_W-1:0] I_HDR   = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] I_SH    = IDX_W'(SH_LEN);
  localparam logic [IDX_W-1:0] I_D_LO  = IDX_W'(HDR_LEN + 1);
  localparam logic [IDX_W-1:0] I_D_HI  = IDX_W'(HDR_LEN + DATA_LEN);
  localparam logic [IDX_W-1:0] I_RLAST = IDX_W'(HDR_LEN + DATA_LEN + 1);
  localparam logic [IDX_W-1:0] I_ELAST = IDX_W'(HDR_LEN + FLUSH_LEN);
  localparam logic [IDX_W-1:0] I_PRE   = IDX_W'(PRE_LEN);

  logic                run_q, run_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [SH_LEN-1:0]   sh_q, sh_d;
  logic                mdo_q, mdo_d;
  logic                oe_q, oe_d;
  logic                rd_q, rd_d;
  logic                tab_q, tab_d;
  logic [DATA_LEN-1:0] rdat_q, rdat_d;
  logic                done_q, done_d;

  logic [IDX_W-1:0]    drv_len;
  logic [IDX_W-1:0]    last_idx;

  assign drv_len  = rd_q ? I_HDR : I_SH;
  assign last_idx = rd_q ? (tab_q ? I_ELAST : I_RLAST) : I_SH;

  always_comb begin
    run_d  = run_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    mdo_d  = mdo_q;
    oe_d   = oe_q;
    rd_d   = rd_q;
    tab_d  = tab_q;
    rdat_d = rdat_q;
    done_d = 1'b0;
    if (!run_q) begin
      if (go) begin
        run_d  = 1'b1;
        idx_d  = '0;
        sh_d   = {{PRE_LEN{1'b1}}, frm.st, frm.op, frm.phy, frm.fld,
                  2'b10, frm.data};
        rd_d   = frm.rd;
        tab_d  = 1'b0;
        rdat_d = '0;
      end
    end else begin
      if (bit_start) begin
        oe_d  = (idx_q < drv_len);
        mdo_d = (idx_q < drv_len) ? sh_q[SH_LEN-1] : 1'b1;
        sh_d  = {sh_q[SH_LEN-2:0], 1'b1};
      end
      if (bit_end) begin
        idx_d = idx_q + IDX_W'(1);
        if (rd_q && (idx_q == I_HDR))
          tab_d = mdio_i;
        if (rd_q && !tab_q && (idx_q >= I_D_LO) && (idx_q <= I_D_HI))
          rdat_d = {rdat_q[DATA_LEN-2:0], mdio_i};
        if (idx_q == last_idx) begin
          run_d  = 1'b0;
          oe_d   = 1'b0;
          mdo_d  = 1'b1;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      tab_q  <= 1'b0;
      rdat_q <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      mdo_q  <= mdo_d;
      oe_q   <= oe_d;
      rd_q   <= rd_d;
      tab_q  <= tab_d;
      rdat_q <= rdat_d;
      done_q <= done_d;
    end
  end

  assign run     = run_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
  assign fdone   = done_q;
  assign ferr    = tab_q;
  assign frd     = tab_q ? {DATA_LEN{1'b1}} : rdat_q;

  // R1: the line holds 1 throughout the preamble
  p_preamble_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && idx_q < I_PRE) |-> mdo_q);

  // R8: pad outputs only move while the clock is low
  p_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdo_q) && $stable(oe_q)));

  // R5: the line stays released once a read frame has passed its header
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && rd_q && idx_q > I_HDR) |-> !oe_q);

  // R7: after a frame ends the line is released
  p_release_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!oe_q && !run_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int LOW_CYC  = 24,
  parameter int HIGH_CYC = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        req_wr,
  input  logic        req_ext,
  input  logic [4:0]  req_phy,
  input  logic [20:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        done,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  ctl_t        st_q, st_d;
  logic        go_q, go_d;
  logic        done_q, done_d;
  logic        err_q, err_d;
  logic [15:0] rdat_q, rdat_d;
  logic        wr_q, wr_d;
  logic        ext_q, ext_d;
  logic [4:0]  phy_q, phy_d;
  logic [20:0] addr_q, addr_d;
  logic [15:0] wdat_q, wdat_d;

  frame_t      frm;
  logic        run, bit_start, bit_end, fdone, ferr;
  logic [15:0] frd;

  always_comb begin
    st_d   = st_q;
    go_d   = 1'b0;
    done_d = 1'b0;
    err_d  = err_q;
    rdat_d = rdat_q;
    wr_d   = wr_q;
    ext_d  = ext_q;
    phy_d  = phy_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    unique case (st_q)
      C_IDLE: begin
        if (start) begin
          wr_d   = req_wr;
          ext_d  = req_ext;
          phy_d  = req_phy;
          addr_d = req_addr;
          wdat_d = req_wdata;
          st_d   = req_ext ? C_ADDR : C_ACC;
          go_d   = 1'b1;
        end
      end
      C_ADDR: begin
        if (fdone) begin
          st_d = C_ACC;
          go_d = 1'b1;
        end
      end
      C_ACC: begin
        if (fdone) begin
          st_d   = C_IDLE;
          done_d = 1'b1;
          err_d  = ferr;
          if (!wr_q) rdat_d = frd;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_comb begin
    frm.phy = phy_q;
    if (st_q == C_ADDR) begin
      frm.st   = ST_EXT;
      frm.op   = OP_ADDR;
      frm.fld  = addr_q[20:16];
      frm.data = addr_q[15:0];
      frm.rd   = 1'b0;
    end else if (ext_q) begin
      frm.st   = ST_EXT;
      frm.op   = wr_q ? OP_WRITE : OP_RD_EXT;
      frm.fld  = addr_q[20:16];
      frm.data = wdat_q;
      frm.rd   = !wr_q;
    end else begin
      frm.st   = ST_DIRECT;
      frm.op   = wr_q ? OP_WRITE : OP_RD_DIR;
      frm.fld  = addr_q[4:0];
      frm.data = wdat_q;
      frm.rd   = !wr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= C_IDLE;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdat_q <= '0;
      wr_q   <= 1'b0;
      ext_q  <= 1'b0;
      phy_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      st_q   <= st_d;
      go_q   <= go_d;
      done_q <= done_d;
      err_q  <= err_d;
      rdat_q <= rdat_d;
      wr_q   <= wr_d;
      ext_q  <= ext_d;
      phy_q  <= phy_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  mdio_phase_gen #(
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .run       (run),
    .mdc       (mdc),
    .bit_start (bit_start),
    .bit_end   (bit_end)
  );

  mdio_frame_eng u_eng (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .go        (go_q),
    .frm       (frm),
    .bit_start (bit_start),
    .bit_end   (bit_end),
    .mdc       (mdc),
    .mdio_i    (mdio_i),
    .run       (run),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .fdone     (fdone),
    .frd       (frd),
    .ferr      (ferr)
  );

  assign busy      = (st_q != C_IDLE);
  assign done      = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdat_q;

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |=> !done_q);

  // R9: an accepted start raises busy on the next cycle
  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start && !busy) |=> busy);

  // R9: busy is already low when done pulses
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |-> !busy);

  // R10: an idle block keeps the bus quiet
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

  localparam int CLK_P = 10;
  localparam int LOWC  = 2;
  localparam int HIGHC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_wr = 1'b0;
  logic        req_ext = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_err, done, busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  mdio_master #(.LOW_CYC(LOWC), .HIGH_CYC(HIGHC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_wr(req_wr),
    .req_ext(req_ext), .req_phy(req_phy), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .done(done), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    int          n;
    logic [63:0] bits;
    string       tag;
  } frm_e;

  typedef struct {
    logic        chk_rd;
    logic [15:0] rd;
    logic        err;
    int          rises;
    string       tag;
  } res_e;

  frm_e fq[$];
  res_e rq[$];

  int total = 0;
  int fails = 0;
  int rises = 0;
  int res_seen = 0;
  int hi_viol = 0;
  int lo_viol = 0;
  int chg_viol = 0;

  logic        rsp_ta = 1'b0;
  logic [15:0] rsp_data = '0;
  event        rd_evt;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic frm_e mk(input logic [1:0] st, input logic [1:0] op,
                              input logic [4:0] phy, input logic [4:0] fld,
                              input logic [15:0] data, input bit rd,
                              input string tag);
    frm_e e;
    logic [63:0] full;
    full = {32'hFFFF_FFFF, st, op, phy, fld, 2'b10, data};
    e.tag = tag;
    if (rd) begin
      e.n = 46;
      e.bits = full >> 18;
    end else begin
      e.n = 64;
      e.bits = full;
    end
    return e;
  endfunction

  // monitor: decode driven bits at each MDC rise and score frames
  initial begin
    logic [63:0] cap;
    int ncap;
    cap = '0;
    ncap = 0;
    forever begin
      @(posedge mdc);
      rises++;
      if (mdio_oe) begin
        cap = {cap[62:0], mdio_o};
        ncap++;
        if (ncap == 46 && ((cap[13:10] == 4'b0110) || (cap[13:10] == 4'b0011)))
          ->rd_evt;
      end else if (ncap > 0) begin
        if (fq.size() == 0) begin
          chk(1'b0, "R9", "unexpected frame", 64'(ncap), 64'd0);
        end else begin
          frm_e e;
          logic [63:0] msk;
          e = fq.pop_front();
          msk = (e.n == 64) ? '1 : ((64'd1 << e.n) - 64'd1);
          chk(ncap == e.n, e.tag, "driven bit count", 64'(ncap), 64'(e.n));
          chk((cap & msk) == e.bits, e.tag, "frame bits", cap & msk, e.bits);
          chk(cap[e.n-1 -: 32] == 32'hFFFF_FFFF, "R1", "preamble",
              64'(cap[e.n-1 -: 32]), 64'hFFFF_FFFF);
          if (e.n == 64)
            chk(cap[17:16] == 2'b10, "R4", "turnaround", 64'(cap[17:16]), 64'd2);
        end
        ncap = 0;
        cap = '0;
      end
    end
  end

  // PHY model: answers read frames on falling MDC edges
  initial begin
    forever begin
      @(rd_evt);
      @(negedge mdc); #1;
      mdio_i = rsp_ta;
      if (!rsp_ta) begin
        for (int i = 15; i >= 0; i--) begin
          @(negedge mdc); #1;
          mdio_i = rsp_data[i];
        end
        @(negedge mdc); #1;
        mdio_i = 1'b1;
      end
    end
  end

  // phase-width and stability watcher, R8
  initial begin
    int hi, lo;
    logic po, poe;
    hi = 0; lo = 0; po = 1'b1; poe = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mdc) begin
          if (hi == 0 && lo > 0 && lo < LOWC) lo_viol++;
          lo = 0;
          hi++;
          if (mdio_o !== po || mdio_oe !== poe) chg_viol++;
        end else begin
          if (hi > 0 && hi != HIGHC) hi_viol++;
          hi = 0;
          lo++;
        end
        po = mdio_o;
        poe = mdio_oe;
      end
    end
  end

  // result monitor: scores each completion
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
        end else begin
          res_e r;
          r = rq.pop_front();
          chk(!busy, "R9", "busy low at done", 64'(busy), 64'd0);
          chk(rsp_err == r.err, r.tag, "error flag", 64'(rsp_err), 64'(r.err));
          if (r.chk_rd)
            chk(rsp_rdata == r.rd, r.tag, "read data", 64'(rsp_rdata), 64'(r.rd));
          chk(rises == r.rises, "R7", "MDC cycles", 64'(rises), 64'(r.rises));
        end
        res_seen++;
      end
    end
  end

  task automatic txn(input bit wr, input bit ext, input logic [4:0] phy,
                     input logic [20:0] addr, input logic [15:0] wdata,
                     input logic [15:0] pdata, input bit ta_bad,
                     input bit poke);
    res_e r;
    int nr, seen;
    string tg;
    tg = ext ? "R3" : "R2";
    nr = 0;
    if (ext) begin
      fq.push_back(mk(2'b00, 2'b00, phy, addr[20:16], addr[15:0], 1'b0, "R3"));
      nr += 65;
      fq.push_back(mk(2'b00, wr ? 2'b01 : 2'b11, phy, addr[20:16], wdata, !wr, tg));
    end else begin
      fq.push_back(mk(2'b01, wr ? 2'b01 : 2'b10, phy, addr[4:0], wdata, !wr, tg));
    end
    nr += wr ? 65 : (ta_bad ? 79 : 64);
    r.chk_rd = !wr;
    r.rd = ta_bad ? 16'hFFFF : pdata;
    r.err = ta_bad;
    r.rises = nr;
    r.tag = wr ? "R4" : (ta_bad ? "R6" : "R5");
    rq.push_back(r);
    rsp_ta = ta_bad;
    rsp_data = pdata;
    seen = res_seen;
    @(negedge clk);
    rises = 0;
    req_wr = wr; req_ext = ext; req_phy = phy; req_addr = addr; req_wdata = wdata;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", "busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req_wr = 1'b0; req_ext = 1'b1; req_phy = 5'h0E; req_addr = 21'h0F0F0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R9", "busy during ignored start", 64'(busy), 64'd1);
    end
    while (res_seen == seen) @(negedge clk);
    @(negedge clk);
    chk(!done, "R9", "done single cycle", 64'(done), 64'd0);
    repeat (5) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mdc, "R10", "mdc after reset", 64'(mdc), 64'd0);
    chk(!mdio_oe, "R10", "oe after reset", 64'(mdio_oe), 64'd0);
    chk(!busy, "R10", "busy after reset", 64'(busy), 64'd0);
    chk(!done, "R10", "done after reset", 64'(done), 64'd0);

    txn(1'b1, 1'b0, 5'h05, 21'h0001A, 16'hA5C3, 16'h0000, 1'b0, 1'b1);
    txn(1'b0, 1'b0, 5'h11, 21'h00003, 16'h0000, 16'h1234, 1'b0, 1'b0);
    txn(1'b0, 1'b0, 5'h1F, 21'h0001F, 16'h0000, 16'h5555, 1'b1, 1'b0);
    txn(1'b1, 1'b1, 5'h02, 21'h1AB_CD, 16'h0F0F, 16'h0000, 1'b0, 1'b0);
    txn(1'b0, 1'b1, 5'h1F, 21'h1FFFFF, 16'h0000, 16'h8001, 1'b0, 1'b0);
    txn(1'b0, 1'b1, 5'h00, 21'h0A_0000, 16'h0000, 16'hBEEF, 1'b1, 1'b0);
    txn(1'b0, 1'b0, 5'h00, 21'h00000, 16'h0000, 16'h0000, 1'b0, 1'b0);

    rises = 0;
    repeat (100) @(negedge clk);
    chk(rises == 0, "R10", "idle MDC cycles", 64'(rises), 64'd0);
    chk(!mdio_oe, "R10", "idle oe", 64'(mdio_oe), 64'd0);
    chk(fq.size() == 0, "R3", "frames left unsent", 64'(fq.size()), 64'd0);
    chk(rq.size() == 0, "R9", "results left", 64'(rq.size()), 64'd0);
    chk(hi_viol == 0, "R8", "high phase width", 64'(hi_viol), 64'd0);
    chk(lo_viol == 0, "R8", "low phase width", 64'(lo_viol), 64'd0);
    chk(chg_viol == 0, "R8", "change while high", 64'(chg_viol), 64'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule